// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block is a small-depth synthesizable model of a synchronous SRAM with no idle cycles needed between reads and writes. On every enabled rising clock edge it accepts one address and control word. Both read data and write data move exactly two enabled cycles after their command edge, so a stream of mixed reads and writes keeps the data bus busy on every cycle. The bidirectional data bus is split into `din`, `dout` and an output-enable flag `dout_oe`.

Three chip enables must all be asserted for an access. A load/advance input picks between loading a new address and stepping an internal burst counter. The counter covers the two low address bits, counts linearly and wraps inside a group of four words. A burst keeps the direction it had when it was loaded. Four active-low byte strobes pick which 9-bit lanes a write updates. An active-high `hold` input blocks an edge completely.

The burst controller is a three-state machine. `ST_IDLE` means no burst is open, `ST_RD` means a read burst is open, and `ST_WR` means a write burst is open. It has four transitions:

- LOAD_RD: a selected load with `rd_wrn`=1 goes from any state to `ST_RD`.
- LOAD_WR: a selected load with `rd_wrn`=0 goes from any state to `ST_WR`.
- DESEL: a load edge while not selected goes from any state to `ST_IDLE`.
- ADVANCE: `ld_adv`=1 leaves the state unchanged. It issues an access only in `ST_RD` or `ST_WR`.

Top module: `zt_sram`

## Requirements
- R1: A selected load edge with `ld_adv`=0 and `rd_wrn`=1 makes `dout` carry the word at `addr` and sets `dout_oe`=1 right after the second following enabled edge. Both hold until the next enabled edge.
- R2: A selected load edge with `ld_adv`=0 and `rd_wrn`=0 makes the block sample `din` on the second following enabled edge and store it at `addr`.
- R3: Byte strobe `be_n[i]` is active low and covers `din[9i+8:9i]`. Any combination may be low on a write, and lanes whose strobe is high keep their old contents.
- R4: An edge with `ld_adv`=1 during an open burst accesses the address whose low 2 bits are the previous ones plus 1 modulo 4, with the upper bits unchanged. The direction is the one latched at load, and `rd_wrn` is ignored on that edge.
- R5: The block is selected only when `ce0_n`=0, `ce1_n`=0 and `ce2`=1. Every other combination counts as not selected.
- R6: A load edge while not selected performs no access and closes any burst. `dout_oe` is 0 after the second following enabled edge.
- R7: An edge with `ld_adv`=1 and no open burst (after reset or a deselect) performs no access.
- R8: An edge sampled with `hold`=1 changes nothing: `dout`, `dout_oe`, memory, burst state and pipeline all stay as they were.
- R9: While `rst_n`=0, and until a read reaches the output, `dout_oe` is 0. No burst is open after reset.
- R10: Reads and writes may alternate on consecutive edges with no idle cycle between them, and accesses take effect in command order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold | input | 1 | 1 blocks the edge entirely |
| ce0_n | input | 1 | Chip enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ld_adv | input | 1 | 0 = load address, 1 = advance burst |
| rd_wrn | input | 1 | 1 = read, 0 = write (used on load edges only) |
| be_n | input | NBYTES | Byte write strobes, active low |
| addr | input | ADDR_W | Word address |
| din | input | NBYTES*BYTE_W | Write data, sampled two enabled edges after its command |
| dout | output | NBYTES*BYTE_W | Read data |
| dout_oe | output | 1 | 1 when the bus would be driven |

## Verification
A wrong burst state shows up as a wrong word or a wrong value of `dout_oe` on the port exactly two enabled cycles after the faulty edge. A wrong counter value gives a read from a neighbouring word. A wrong latched direction either drops `dout_oe` or drives a read where a write was meant. A write that goes to the wrong lane or wrong address stays hidden until that word is read again, so the bench reads back every location it writes. Blocked edges are mixed into long random traffic, so any register that moves during `hold` is caught on the following cycle.

// File: rtl/zt_sram_pkg.sv
package zt_sram_pkg;
    timeunit 1ns; timeprecision 1ps;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RD   = 2'd1,
        ST_WR   = 2'd2
    } burst_state_t;
endpackage

// File: rtl/zt_sram_ctl.sv
module zt_sram_ctl
    import zt_sram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int NBYTES     = 4,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              sel,
    input  logic              ld_adv,
    input  logic              rd_wrn,
    input  logic [NBYTES-1:0] be_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cmd_valid,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [NBYTES-1:0] cmd_be
);
    timeunit 1ns; timeprecision 1ps;

    burst_state_t      state_q, state_d;
    logic [ADDR_W-1:0] base_q, base_d, step_addr;

    assign step_addr = {base_q[ADDR_W-1:BURST_BITS],
                        base_q[BURST_BITS-1:0] + BURST_BITS'(1)};

    // next state and burst base
    always_comb begin
        state_d = state_q;
        base_d  = base_q;
        if (!ld_adv) begin
            if (sel) begin
                state_d = rd_wrn ? ST_RD : ST_WR;
                base_d  = addr;
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE:      base_d = base_q;
                ST_RD, ST_WR: base_d = step_addr;
            endcase
        end
    end

    // command issued on this edge
    always_comb begin
        cmd_valid = 1'b0;
        cmd_wr    = 1'b0;
        cmd_addr  = base_q;
        cmd_be    = ~be_n;
        if (!ld_adv) begin
            cmd_valid = sel;
            cmd_wr    = sel && !rd_wrn;
            cmd_addr  = addr;
        end else begin
            unique case (state_q)
                ST_IDLE: cmd_valid = 1'b0;
                ST_RD: begin
                    cmd_valid = 1'b1;
                    cmd_addr  = step_addr;
                end
                ST_WR: begin
                    cmd_valid = 1'b1;
                    cmd_wr    = 1'b1;
                    cmd_addr  = step_addr;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            base_q  <= '0;
        end else if (!hold) begin
            state_q <= state_d;
            base_q  <= base_d;
        end
    end

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && ld_adv && state_q != ST_IDLE) |=>
            (base_q[ADDR_W-1:BURST_BITS] == $past(base_q[ADDR_W-1:BURST_BITS])) &&
            (base_q[BURST_BITS-1:0] == $past(base_q[BURST_BITS-1:0]) + BURST_BITS'(1)));

    p_dir_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && ld_adv) |=> (state_q == $past(state_q)));

    p_desel_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !ld_adv && !sel) |=> (state_q == ST_IDLE));
endmodule

// File: rtl/zt_sram_pipe.sv
module zt_sram_pipe #(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int LAT    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold,
    input  logic              in_valid,
    input  logic              in_wr,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [NBYTES-1:0] in_be,
    output logic              out_valid,
    output logic              out_wr,
    output logic [ADDR_W-1:0] out_addr,
    output logic [NBYTES-1:0] out_be
);
    timeunit 1ns; timeprecision 1ps;

    localparam int CW = 2 + ADDR_W + NBYTES;

    logic [CW-1:0] stg_q [LAT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < LAT; i++) stg_q[i] <= '0;
        end else if (!hold) begin
            stg_q[0] <= {in_valid, in_wr, in_addr, in_be};
            for (int i = 1; i < LAT; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign {out_valid, out_wr, out_addr, out_be} = stg_q[LAT-1];

    p_pipe_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(stg_q[LAT-1]));
endmodule

// File: rtl/zt_sram_array.sv
module zt_sram_array #(
    parameter int ADDR_W = 8,
    parameter int NBYTES = 4,
    parameter int BYTE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold,
    input  logic                     ex_valid,
    input  logic                     ex_wr,
    input  logic [ADDR_W-1:0]        ex_addr,
    input  logic [NBYTES-1:0]        ex_be,
    input  logic [NBYTES*BYTE_W-1:0] din,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_oe
);
    timeunit 1ns; timeprecision 1ps;

    localparam int DEPTH = 1 << ADDR_W;

    logic do_rd, do_wr;
    assign do_rd = !hold && ex_valid && !ex_wr;
    assign do_wr = !hold && ex_valid && ex_wr;

    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
        logic [BYTE_W-1:0] lane_mem [DEPTH];
        logic [BYTE_W-1:0] rd_q;

        always_ff @(posedge clk) begin
            if (do_wr && ex_be[b]) lane_mem[ex_addr] <= din[b*BYTE_W +: BYTE_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     rd_q <= '0;
            else if (do_rd) rd_q <= lane_mem[ex_addr];
        end

        assign dout[b*BYTE_W +: BYTE_W] = rd_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     dout_oe <= 1'b0;
        else if (!hold) dout_oe <= ex_valid && !ex_wr;
    end

    p_oe_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dout_oe) |-> $past(ex_valid && !ex_wr && !hold));

    p_oe_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dout_oe) |-> $past(!hold && !(ex_valid && !ex_wr)));
endmodule

// File: rtl/zt_sram.sv
module zt_sram #(
    parameter int ADDR_W     = 8,
    parameter int NBYTES     = 4,
    parameter int BYTE_W     = 9,
    parameter int BURST_BITS = 2,
    parameter int LAT        = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     hold,
    input  logic                     ce0_n,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ld_adv,
    input  logic                     rd_wrn,
    input  logic [NBYTES-1:0]        be_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [NBYTES*BYTE_W-1:0] din,
    output logic [NBYTES*BYTE_W-1:0] dout,
    output logic                     dout_oe
);
    timeunit 1ns; timeprecision 1ps;

    logic              sel;
    logic              c_valid, c_wr, x_valid, x_wr;
    logic [ADDR_W-1:0] c_addr, x_addr;
    logic [NBYTES-1:0] c_be, x_be;

    assign sel = !ce0_n && !ce1_n && ce2;

    zt_sram_ctl #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BURST_BITS(BURST_BITS)) u_ctl (
        .clk(clk), .rst_n(rst_n), .hold(hold), .sel(sel), .ld_adv(ld_adv),
        .rd_wrn(rd_wrn), .be_n(be_n), .addr(addr),
        .cmd_valid(c_valid), .cmd_wr(c_wr), .cmd_addr(c_addr), .cmd_be(c_be)
    );

    zt_sram_pipe #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .LAT(LAT)) u_pipe (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .in_valid(c_valid), .in_wr(c_wr), .in_addr(c_addr), .in_be(c_be),
        .out_valid(x_valid), .out_wr(x_wr), .out_addr(x_addr), .out_be(x_be)
    );

    zt_sram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
        .clk(clk), .rst_n(rst_n), .hold(hold),
        .ex_valid(x_valid), .ex_wr(x_wr), .ex_addr(x_addr), .ex_be(x_be),
        .din(din), .dout(dout), .dout_oe(dout_oe)
    );

    p_bus_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> ($stable(dout) && $stable(dout_oe)));

    p_reset_quiet_r9: assert property (@(posedge clk)
        !rst_n |-> !dout_oe);
endmodule

// File: tb/zt_sram_bench.sv
module zt_sram_bench;
    timeunit 1ns; timeprecision 1ps;

    localparam int AW = 8;
    localparam int NB = 4;
    localparam int BW = 9;
    localparam int DW = NB * BW;

    typedef struct {
        bit          v;
        bit          w;
        int          a;
        bit [NB-1:0] be;
    } op_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          hold = 1'b0;
    logic          ce0_n = 1'b1, ce1_n = 1'b1, ce2 = 1'b0;
    logic          ld_adv = 1'b0, rd_wrn = 1'b1;
    logic [NB-1:0] be_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    always #2.5 clk = ~clk;

    zt_sram u_zt_sram (
        .clk(clk), .rst_n(rst_n), .hold(hold), .ce0_n(ce0_n), .ce1_n(ce1_n), .ce2(ce2),
        .ld_adv(ld_adv), .rd_wrn(rd_wrn), .be_n(be_n), .addr(addr), .din(din),
        .dout(dout), .dout_oe(dout_oe)
    );

    // behavioural reference
    logic [DW-1:0] ref_mem [1 << AW];
    op_t           pend[$];
    int            m_state = 0;   // 0 none, 1 read burst, 2 write burst
    int            m_base = 0;
    bit            exp_oe = 1'b0;
    logic [DW-1:0] exp_dout = '0;

    always @(posedge clk) begin
        op_t o;
        op_t n;
        if (!rst_n) begin
            pend = {};
            n = '{v: 1'b0, w: 1'b0, a: 0, be: '0};
            pend.push_back(n);
            pend.push_back(n);
            m_state = 0;
            exp_oe = 1'b0;
        end else if (!hold) begin
            o = pend.pop_front();
            if (o.v && o.w)
                for (int b = 0; b < NB; b++)
                    if (o.be[b]) ref_mem[o.a][b*BW +: BW] = din[b*BW +: BW];
            exp_oe = o.v && !o.w;
            if (exp_oe) exp_dout = ref_mem[o.a];
            n = '{v: 1'b0, w: 1'b0, a: 0, be: ~be_n};
            if (!ld_adv) begin
                if (!ce0_n && !ce1_n && ce2) begin
                    m_state = rd_wrn ? 1 : 2;
                    m_base = int'(addr);
                    n.v = 1'b1; n.w = !rd_wrn; n.a = m_base;
                end else begin
                    m_state = 0;
                end
            end else if (m_state != 0) begin
                m_base = (m_base & ~3) | ((m_base + 1) & 3);
                n.v = 1'b1; n.w = (m_state == 2); n.a = m_base;
            end
            pend.push_back(n);
        end
    end

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R9";
    bit    done = 1'b0;

    always @(negedge clk) begin
        n_cmp++;
        if (dout_oe !== exp_oe) begin
            n_bad++;
            $display("FAIL %s: dout_oe=%0b expected %0b at %0t", cur_req, dout_oe, exp_oe, $time);
        end else if (exp_oe && dout !== exp_dout) begin
            n_bad++;
            $display("FAIL %s: dout=%h expected %h at %0t", cur_req, dout, exp_dout, $time);
        end
    end

    task automatic cyc(input bit h, input bit c0, input bit c1, input bit c2,
                       input bit la, input bit rw, input bit [NB-1:0] ben, input int a);
        @(negedge clk);
        hold = h; ce0_n = c0; ce1_n = c1; ce2 = c2;
        ld_adv = la; rd_wrn = rw; be_n = ben; addr = AW'(a);
        din = {$urandom, $urandom};
    endtask

    task automatic ld(input bit rw, input bit [NB-1:0] ben, input int a);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, rw, ben, a);
    endtask

    task automatic adv(input bit rw, input bit [NB-1:0] ben);
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, rw, ben, int'($urandom_range(255)));
    endtask

    task automatic desel();
        cyc(1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, '1, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            summary();
        end
    end

    initial begin
        // R9: reset keeps the bus released; R7: advances with no burst do nothing
        repeat (3) desel();
        @(negedge clk) rst_n = 1'b1;
        cur_req = "R7";
        repeat (4) adv(1'b1, '0);

        // R4: write bursts fill memory; rd_wrn=1 on advance edges is ignored
        cur_req = "R4";
        for (int k = 0; k < 64; k++) begin
            ld(1'b0, '0, k * 4);
            repeat (3) adv(1'b1, '0);
        end

        // R1: read bursts from unaligned starts wrap in groups of four
        cur_req = "R1";
        for (int k = 0; k < 16; k++) begin
            ld(1'b1, '1, int'($urandom_range(255)));
            repeat (5) adv(1'b0, '0);
        end

        // R2 / R10: alternate single writes and reads on consecutive edges
        cur_req = "R2";
        for (int k = 0; k < 40; k++) begin
            int a = int'($urandom_range(255));
            ld(1'b0, '0, a);
            ld(1'b1, '1, a);
        end
        cur_req = "R10";
        for (int k = 0; k < 40; k++) begin
            ld(1'b1, '1, k);
            ld(1'b0, '0, k);
            ld(1'b1, '1, k);
        end

        // R3: partial byte writes then read back
        cur_req = "R3";
        for (int k = 0; k < 16; k++) begin
            ld(1'b0, NB'(k), 9);
            ld(1'b1, '1, 9);
        end
        ld(1'b0, 4'b1110, 20);
        adv(1'b1, 4'b0101);
        adv(1'b1, 4'b1111);
        ld(1'b1, '1, 20);
        repeat (3) adv(1'b0, '0);

        // R5: every non-selecting enable combination suppresses a read
        cur_req = "R5";
        for (int c = 0; c < 8; c++) begin
            cyc(1'b0, c[0], c[1], c[2], 1'b0, 1'b1, '1, 33);
            cyc(1'b0, c[0], c[1], c[2], 1'b1, 1'b1, '1, 33);
        end

        // R6: deselect mid-burst releases the bus two cycles later
        cur_req = "R6";
        ld(1'b1, '1, 40);
        adv(1'b1, '1);
        desel();
        repeat (3) adv(1'b1, '1);
        cur_req = "R7";
        desel();
        repeat (5) adv(1'b0, '0);

        // R8: blocked edges freeze pipeline and outputs
        cur_req = "R8";
        ld(1'b1, '1, 50);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 51);
        cyc(1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, '0, 52);
        adv(1'b1, '1);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, '0, 53);
        repeat (3) adv(1'b1, '1);
        ld(1'b0, '0, 60);
        cyc(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, '1, 61);
        adv(1'b1, '0);
        ld(1'b1, '1, 60);
        repeat (3) adv(1'b1, '1);

        // R10: long random mixed traffic
        cur_req = "R10";
        for (int k = 0; k < 3000; k++) begin
            bit h  = ($urandom_range(9) == 0);
            bit s  = ($urandom_range(9) != 0);
            bit la = ($urandom_range(9) < 4);
            cyc(h, !s, !s && $urandom_range(1) == 1 ? 1'b0 : !s, s,
                la, $urandom_range(1) == 1, NB'($urandom), int'($urandom_range(255)));
        end
        repeat (4) desel();
        done = 1'b1;
        summary();
    end
endmodule